// File: doc/BRIEF.md
# SCSI Controller Command and Interrupt Registers

This block is the host-facing register bank and command decoder of a small SCSI bus controller. A byte-wide bus reaches sixteen registers spaced four bytes apart. The block keeps a write copy of every register as the host wrote it, and a read copy that the host sees. A status byte, an interrupt-cause byte and a sequence-step byte are updated by commands. One interrupt line is held high until the host reads the cause register.

Command bytes written to the command register do several things. They select DMA or programmed transfer mode. They flush the FIFO, reset the chip or reset the bus. They select a target, with or without stopping after the message phase. They start an information transfer, and they run the two completion sequences. Start pulses go to the neighbouring FIFO and DMA engines. Whether a target answers is given by a present-bit per bus ID.

Top module: `scsi_cmd_regs`

## Requirements
- R1: The register index is `addr[5:2]`; address bits [1:0] are ignored, so all four byte addresses of a slot reach the same register.
- R2: After reset, every read and write copy is zero except read register 14, which holds 0x04; `irq`, `dma_mode` and `cmd_collect` are low.
- R3: A write to register 8 or to registers 12..15 is copied into the read copy. A write to register 11 keeps only the bits under mask 0x15. Writes to registers 4..7, 9 and 10 leave the read copies unchanged.
- R4: A write to register 0 or 1 clears status bit 4 (terminal count, 0x10).
- R5: A write to register 3 stores the byte in read register 3. Bit 7 set turns DMA mode on and loads read registers 0 and 1 from write registers 0 and 1. Bit 7 clear turns DMA mode off.
- R6: A read of register 5 returns the cause byte. After that cycle, status bits 7, 6 and 5 (0x80 interrupt, 0x40 gross error, 0x20 parity error) are clear and `irq` is low.
- R7: Command 0x01 sets cause 0x08 and sequence step (register 6) 0. It pulses `fifo_flush` for one cycle and does not raise `irq`.
- R8: Command 0x02 returns the block to the R2 state.
- R9: Command 0x03 sets cause 0x80. It raises `irq` only when bit 6 of write register 8 is clear.
- R10: Command 0x42 or 0x43 takes the target ID from write register 4 bits [2:0]. If that ID's `tgt_present` bit is clear, the result is status 0x80, cause 0x20 and step 0, and `irq` rises.
- R11: When the target is present, command 0x42 gives cause 0x18 and step 4, sets status bit 7 and raises `irq`. Command 0x43 instead sets status 0x92 (phase 2 = command) and also raises `cmd_collect`.
- R12: Command 0x10 pulses `xfer_start` for one cycle and drops `cmd_collect`. In DMA mode it also clears status bit 4.
- R13: Command 0x11 sets status 0x93 (phase 3 = status), cause 0x18 and step 4. Command 0x12 sets the same status with cause 0x20 and step 0. Both raise `irq`.
- R14: Any other command code changes only read register 3 and `dma_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Bus access this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Byte address; index is addr[5:2] |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read copy of the addressed register |
| tgt_present | input | NUM_IDS | One bit per bus ID whose target answers selection |
| irq | output | 1 | Level interrupt request |
| dma_mode | output | 1 | DMA transfer mode selected |
| cmd_collect | output | 1 | Command bytes are being gathered after select-and-stop |
| fifo_flush | output | 1 | One-cycle pulse to the FIFO engine |
| xfer_start | output | 1 | One-cycle pulse to the DMA/transfer engine |

## Verification
The bench builds the block with the default `NUM_IDS` of 8, so every value of the 3-bit target field maps to a real present bit. Driving only ID 2 as present lets both the absent-target and the present-target selection outcomes be reached from one bit of the ID field. The default revision value 0x04 makes the reset image of register 14 visible after both the pin reset and the chip-reset command.

// File: rtl/scsi_cmd_regs.sv
module scsi_cmd_regs #(
  parameter int NUM_IDS = 8,
  parameter logic [7:0] REV_ID = 8'h04
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               we,
  input  logic [5:0]         addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic [NUM_IDS-1:0] tgt_present,
  output logic               irq,
  output logic               dma_mode,
  output logic               cmd_collect,
  output logic               fifo_flush,
  output logic               xfer_start
);
  localparam int NREG = 16;

  logic [7:0] rr [NREG];
  logic [7:0] wr_r [NREG];

  wire [3:0] idx    = addr[5:2];
  wire       wr_en  = cs & we;
  wire       rd_int = cs & ~we & (idx == 4'd5);
  wire       is_cmd = wr_en & (idx == 4'd3);
  wire [6:0] code   = wdata[6:0];
  wire       chip_rst = is_cmd & (code == 7'h02);
  wire [7:0] pres8  = 8'(tgt_present);
  wire       hit    = pres8[wr_r[4][2:0]];

  logic irq_set;
  always_comb begin
    irq_set = 1'b0;
    if (is_cmd)
      case (code)
        7'h03:               irq_set = ~wr_r[8][6];
        7'h42, 7'h11, 7'h12: irq_set = 1'b1;
        7'h43:               irq_set = 1'b1;
        default:             irq_set = 1'b0;
      endcase
  end

  assign rdata = rr[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        rr[i]   <= (i == 14) ? REV_ID : 8'h00;
        wr_r[i] <= 8'h00;
      end
      irq <= 1'b0; dma_mode <= 1'b0; cmd_collect <= 1'b0;
      fifo_flush <= 1'b0; xfer_start <= 1'b0;
    end else if (chip_rst) begin
      for (int i = 0; i < NREG; i++) begin
        rr[i]   <= (i == 14) ? REV_ID : 8'h00;
        wr_r[i] <= 8'h00;
      end
      irq <= 1'b0; dma_mode <= 1'b0; cmd_collect <= 1'b0;
      fifo_flush <= 1'b0; xfer_start <= 1'b0;
    end else begin
      fifo_flush <= 1'b0;
      xfer_start <= 1'b0;
      irq <= irq_set | (irq & ~rd_int);
      if (rd_int) rr[4][7:5] <= 3'b000;
      if (wr_en) begin
        wr_r[idx] <= wdata;
        case (idx)
          4'd0, 4'd1: rr[4][4] <= 1'b0;
          4'd8, 4'd12, 4'd13, 4'd14, 4'd15: rr[idx] <= wdata;
          4'd11: rr[11] <= wdata & 8'h15;
          4'd3: begin
            rr[3]    <= wdata;
            dma_mode <= wdata[7];
            if (wdata[7]) begin
              rr[0] <= wr_r[0];
              rr[1] <= wr_r[1];
            end
            case (code)
              7'h01: begin rr[5] <= 8'h08; rr[6] <= 8'h00; fifo_flush <= 1'b1; end
              7'h03: rr[5] <= 8'h80;
              7'h10: begin
                xfer_start  <= 1'b1;
                cmd_collect <= 1'b0;
                if (wdata[7]) rr[4][4] <= 1'b0;
              end
              7'h11: begin rr[4] <= 8'h93; rr[5] <= 8'h18; rr[6] <= 8'h04; end
              7'h12: begin rr[4] <= 8'h93; rr[5] <= 8'h20; rr[6] <= 8'h00; end
              7'h42, 7'h43: begin
                if (!hit) begin
                  rr[4] <= 8'h80; rr[5] <= 8'h20; rr[6] <= 8'h00;
                end else begin
                  rr[5] <= 8'h18; rr[6] <= 8'h04;
                  if (code == 7'h43) begin
                    rr[4] <= 8'h92;
                    cmd_collect <= 1'b1;
                  end else begin
                    rr[4][7] <= 1'b1;
                  end
                end
              end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module scsi_cmd_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       we,
  input logic [5:0] addr,
  input logic [7:0] wdata,
  input logic       irq,
  input logic       dma_mode,
  input logic [7:0] status,
  input logic [7:0] r11,
  input logic [7:0] rev,
  input logic       w8_b6
);
  wire       wr  = cs & we;
  wire [3:0] ix  = addr[5:2];
  wire       cmd = wr & (ix == 4'd3);

  p_read_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && ix == 4'd5) |=> (!irq && status[7:5] == 3'b000));

  p_count_write_clears_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (ix == 4'd0 || ix == 4'd1)) |=> !status[4]);

  p_reg11_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ix == 4'd11) |=> ((r11 & 8'hEA) == 8'h00));

  p_dma_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && wdata[7] && wdata[6:0] != 7'h02) |=> dma_mode);

  p_bus_reset_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && wdata[6:0] == 7'h03 && w8_b6 && !irq) |=> !irq);

  p_chip_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && wdata[6:0] == 7'h02) |=> (rev == 8'h04 && !irq && !dma_mode));
endmodule

bind scsi_cmd_regs scsi_cmd_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
  .irq(irq), .dma_mode(dma_mode), .status(rr[4]), .r11(rr[11]),
  .rev(rr[14]), .w8_b6(wr_r[8][6])
);

// File: tb/scsi_cmd_regs_test.sv
module scsi_cmd_regs_test;
  logic clk = 0, rst_n = 0, cs = 0, we = 0;
  logic [5:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [7:0] tgt_present = 8'b0000_0100;
  logic irq, dma_mode, cmd_collect, fifo_flush, xfer_start;

  int checks = 0, fails = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  scsi_cmd_regs uut (.*);

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); cs = 1; we = 1; addr = 6'(a); wdata = 8'(d);
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); cs = 1; we = 0; addr = 6'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); cs = 0;
  endtask

  always @(posedge clk) begin
    if (cs && !we) begin
      if (exp_q.size() == 0) chk(1, 0, "scoreboard underflow");
      else chk(int'(rdata), exp_q.pop_front(), tag_q.pop_front());
    end
  end

  function automatic int r(input int n); return n * 4; endfunction

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(irq, 0, "R2 irq"); chk(dma_mode, 0, "R2 dma"); chk(cmd_collect, 0, "R2 collect");
    rd(r(14), 8'h04, "R2 rev");
    rd(r(4), 0, "R2 status"); rd(r(5), 0, "R2 cause");

    wr(r(8), 8'h5A);  rd(r(8), 8'h5A, "R3 reg8");
    rd(r(8) + 3, 8'h5A, "R1 low bits ignored");
    wr(r(11), 8'hFF); rd(r(11), 8'h15, "R3 reg11 mask");
    wr(r(12) + 1, 8'hA5); rd(r(12), 8'hA5, "R1 R3 reg12");
    wr(r(9), 8'h77);  rd(r(9), 0, "R3 reg9 ignored");
    wr(r(6), 8'h33);  rd(r(6), 0, "R3 reg6 ignored");

    wr(r(0), 8'h34); wr(r(1), 8'h12);
    rd(r(0), 0, "R5 count not loaded yet");
    wr(r(3), 8'h80); chk(dma_mode, 1, "R5 dma on");
    rd(r(0), 8'h34, "R5 count low"); rd(r(1), 8'h12, "R5 count high");
    rd(r(3), 8'h80, "R5 cmd copy");
    wr(r(3), 8'h00); chk(dma_mode, 0, "R5 dma off");

    wr(r(3), 8'h01); chk(fifo_flush, 1, "R7 flush pulse");
    @(negedge clk); chk(fifo_flush, 0, "R7 pulse width");
    chk(irq, 0, "R7 no irq");
    rd(r(5), 8'h08, "R7 cause"); rd(r(6), 0, "R7 step");

    wr(r(4), 8'h05); wr(r(3), 8'h42);
    chk(irq, 1, "R10 irq");
    rd(r(4), 8'h80, "R10 status"); rd(r(6), 0, "R10 step");
    rd(r(5), 8'h20, "R10 cause");
    chk(irq, 0, "R6 irq dropped");
    rd(r(4), 8'h00, "R6 status cleared");

    wr(r(4), 8'h02); wr(r(3), 8'h42);
    chk(irq, 1, "R11 irq 0x42");
    rd(r(6), 4, "R11 step"); rd(r(5), 8'h18, "R11 cause");
    wr(r(3), 8'h43);
    chk(cmd_collect, 1, "R11 collect");
    rd(r(4), 8'h92, "R11 status"); rd(r(5), 8'h18, "R11 cause stop");
    rd(r(4), 8'h12, "R6 status after read");

    wr(r(3), 8'h90);
    chk(xfer_start, 1, "R12 start pulse"); chk(cmd_collect, 0, "R12 collect off");
    rd(r(4), 8'h02, "R12 tc cleared");

    wr(r(3), 8'h11); chk(irq, 1, "R13 irq");
    rd(r(4), 8'h93, "R13 status"); rd(r(6), 4, "R13 step");
    rd(r(5), 8'h18, "R13 cause");
    wr(r(1), 8'h00); rd(r(4), 8'h03, "R4 tc cleared");
    wr(r(3), 8'h12); chk(irq, 1, "R13 irq 0x12");
    rd(r(5), 8'h20, "R13 cause 0x12"); rd(r(6), 0, "R13 step 0x12");

    wr(r(8), 8'h40); wr(r(3), 8'h03);
    chk(irq, 0, "R9 masked");
    rd(r(5), 8'h80, "R9 cause");
    wr(r(8), 8'h00); wr(r(3), 8'h03);
    chk(irq, 1, "R9 irq");
    rd(r(5), 8'h80, "R9 cause unmasked");

    wr(r(3), 8'hC4);
    chk(dma_mode, 1, "R14 dma bit"); chk(irq, 0, "R14 no irq");
    chk(fifo_flush | xfer_start, 0, "R14 no pulse");
    rd(r(5), 8'h80, "R14 cause kept"); rd(r(6), 0, "R14 step kept");
    rd(r(4), 8'h13, "R14 status kept"); rd(r(3), 8'hC4, "R14 cmd copy");

    wr(r(12), 8'hEE); wr(r(0), 8'h55); wr(r(3), 8'h03);
    chk(irq, 1, "R8 setup irq");
    wr(r(3), 8'h02);
    chk(irq, 0, "R8 irq"); chk(dma_mode, 0, "R8 dma");
    rd(r(14), 8'h04, "R8 rev"); rd(r(12), 0, "R8 reg12");
    rd(r(5), 0, "R8 cause"); rd(r(3), 0, "R8 cmd");
    wr(r(3), 8'h80); rd(r(0), 0, "R8 write copy cleared");

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule